// File: doc/BRIEF.md
# Signed-Range Barrel Shifter

This block is a purely combinational shifter for a 40-bit DSP datapath. It sits directly after the ALU and shifts the ALU result within the same cycle, so the shifted word can be stored to memory or to an accumulator without an added pipeline stage. The amount is a 6-bit two's-complement count. Zero and positive values move the word toward the most significant bit. Negative values move it toward the least significant bit by the magnitude of the count.

A mode input chooses between arithmetic and logical behaviour. Arithmetic right shifts replicate the sign bit (bit 39). Logical right shifts bring in zeros. Left shifts always bring in zeros. An overflow flag reports when an arithmetic left shift has lost significant bits, which means the signed value no longer fits in the word.

Inside, a bit reversal at the input and at the output lets left and right shifts share one chain of 2:1 multiplexer stages. The chain has five stages, which move the word by 1, 2, 4, 8 and 16 positions.

Top module: `sr_barrel_shifter`

## Requirements
- R1: A count of +1 to +31 shifts `shf_din` left by that many positions, and zeros enter at bit 0 in both modes.
- R2: A count from -1 to -16 (encoded 6'h3F down to 6'h30) shifts `shf_din` right by the magnitude of the count.
- R3: On a right shift with `shf_arith` = 1, the vacated upper bits are copies of input bit 39. With `shf_arith` = 0 they are zero.
- R4: A count in the unused range -17 to -32 (6'h2F down to 6'h20) is treated as -16.
- R5: A count of 0 passes `shf_din` to `shf_dout` unchanged, and `shf_ovf` is 0.
- R6: With `shf_arith` = 1 and a positive count n, `shf_ovf` is 1 exactly when input bits 39 down to 39-n are not all equal. This is the case when a bit shifted out differs from the new bit 39.
- R7: `shf_ovf` is 0 whenever `shf_arith` = 0, and on every right shift.
- R8: The block holds no state. `shf_dout` and `shf_ovf` follow a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shf_din | input | 40 | Word to be shifted (ALU result) |
| shf_cnt | input | 6 | Signed shift count, two's complement; negative shifts right |
| shf_arith | input | 1 | 1 = arithmetic mode, 0 = logical mode |
| shf_dout | output | 40 | Shifted word |
| shf_ovf | output | 1 | Arithmetic left shift lost significant bits |

## Verification
The in-line checks assume that the inputs have settled to known values when they are evaluated. They also assume that the count decoder only sees the 6-bit two's-complement encoding, which covers every code including the clamped range. The bench changes the inputs only away from the clock edge and waits before it samples. It applies every one of the 64 count codes in both modes to several patterns: a lone sign bit, all ones, a mixed word and a low bit. The unused negative codes are exercised alongside the valid ones, with no special handling.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    // Datapath geometry
    localparam int SHF_DATA_W = 40;
    localparam int SHF_CNT_W  = 6;
    localparam int SHF_MAG_W  = SHF_CNT_W - 1;
    localparam int SHF_MAX_RT = 16;

    typedef enum logic {
        SHF_LOGICAL = 1'b0,
        SHF_ARITH   = 1'b1
    } shf_mode_e;

    // Decoded shift control
    typedef struct packed {
        logic                 go_right;
        logic [SHF_MAG_W-1:0] mag;
    } shf_ctrl_t;

    // Two's-complement magnitude of a count word
    function automatic logic [SHF_CNT_W-1:0] cnt_abs(input logic [SHF_CNT_W-1:0] c);
        return c[SHF_CNT_W-1] ? (~c + SHF_CNT_W'(1)) : c;
    endfunction

endpackage

// File: rtl/bsh_count_decode.sv
module bsh_count_decode
    import bsh_pkg::*;
#(
    parameter int CNT_W  = SHF_CNT_W,
    parameter int MAX_RT = SHF_MAX_RT
) (
    input  logic [CNT_W-1:0] cnt,
    output shf_ctrl_t        ctrl
);
    localparam int MAG_W = CNT_W - 1;

    logic             neg;
    logic [CNT_W-1:0] abs_full;

    always_comb begin
        neg      = cnt[CNT_W-1];
        abs_full = cnt_abs(cnt);
        ctrl.go_right = neg;
        if (neg && (abs_full > CNT_W'(MAX_RT)))
            ctrl.mag = MAG_W'(MAX_RT);
        else
            ctrl.mag = abs_full[MAG_W-1:0];
    end

    // R4: a right shift never exceeds the supported span
    always_comb begin
        if (ctrl.go_right)
            p_right_span_r4: assert (ctrl.mag != '0 && int'(ctrl.mag) <= MAX_RT);
    end

endmodule

// File: rtl/bsh_mux_chain.sv
module bsh_mux_chain
    import bsh_pkg::*;
#(
    parameter int DATA_W = SHF_DATA_W,
    parameter int MAG_W  = SHF_MAG_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [MAG_W-1:0]  mag,
    input  logic              fill,
    output logic [DATA_W-1:0] dout
);
    // One 2:1 multiplexer rank per magnitude bit, moving toward bit 0
    logic [DATA_W-1:0] stage [MAG_W+1];

    assign stage[0] = din;

    for (genvar s = 0; s < MAG_W; s++) begin : g_rank
        localparam int SH = 1 << s;
        assign stage[s+1] = mag[s] ? {{SH{fill}}, stage[s][DATA_W-1:SH]} : stage[s];
    end

    assign dout = stage[MAG_W];

    // a zero magnitude leaves the word untouched
    always_comb begin
        if (mag == '0)
            p_idle_chain_r5: assert (dout == din);
    end

endmodule

// File: rtl/bsh_ovf_detect.sv
module bsh_ovf_detect
    import bsh_pkg::*;
#(
    parameter int DATA_W = SHF_DATA_W,
    parameter int MAG_W  = SHF_MAG_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [MAG_W-1:0]  mag,
    input  logic              enable,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic differ;

    // Bits MSB-1 down to MSB-mag must all equal the MSB
    always_comb begin
        differ = 1'b0;
        for (int i = 0; i < MSB; i++) begin
            if (i >= MSB - int'(mag))
                differ = differ | (din[i] ^ din[MSB]);
        end
        ovf = enable & differ;
    end

    always_comb begin
        if (!enable)
            p_gated_r7: assert (!ovf);
    end

endmodule

// File: rtl/sr_barrel_shifter.sv
module sr_barrel_shifter
    import bsh_pkg::*;
#(
    parameter int DATA_W = SHF_DATA_W,
    parameter int CNT_W  = SHF_CNT_W,
    parameter int MAX_RT = SHF_MAX_RT
) (
    input  logic [DATA_W-1:0] shf_din,
    input  logic [CNT_W-1:0]  shf_cnt,
    input  logic              shf_arith,
    output logic [DATA_W-1:0] shf_dout,
    output logic              shf_ovf
);
    localparam int MAG_W = CNT_W - 1;
    localparam int MSB   = DATA_W - 1;

    shf_ctrl_t         ctrl;
    shf_mode_e         mode;
    logic [DATA_W-1:0] din_rev;
    logic [DATA_W-1:0] chain_in;
    logic [DATA_W-1:0] chain_out;
    logic [DATA_W-1:0] chain_rev;
    logic              fill;

    assign mode = shf_mode_e'(shf_arith);

    bsh_count_decode #(
        .CNT_W  (CNT_W),
        .MAX_RT (MAX_RT)
    ) u_decode (
        .cnt  (shf_cnt),
        .ctrl (ctrl)
    );

    // Bit reversal lets a left shift reuse the right-shift chain
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign din_rev[i]   = shf_din[MSB-i];
        assign chain_rev[i] = chain_out[MSB-i];
    end

    assign chain_in = ctrl.go_right ? shf_din : din_rev;
    assign fill     = ctrl.go_right && (mode == SHF_ARITH) && shf_din[MSB];

    bsh_mux_chain #(
        .DATA_W (DATA_W),
        .MAG_W  (MAG_W)
    ) u_chain (
        .din  (chain_in),
        .mag  (ctrl.mag),
        .fill (fill),
        .dout (chain_out)
    );

    assign shf_dout = ctrl.go_right ? chain_out : chain_rev;

    bsh_ovf_detect #(
        .DATA_W (DATA_W),
        .MAG_W  (MAG_W)
    ) u_ovf (
        .din    (shf_din),
        .mag    (ctrl.mag),
        .enable (!ctrl.go_right && (mode == SHF_ARITH)),
        .ovf    (shf_ovf)
    );

    // Port-level properties
    always_comb begin
        if (shf_cnt == '0)
            p_pass_through_r5: assert (shf_dout == shf_din && !shf_ovf);
        if (!shf_arith)
            p_no_overflow_r7: assert (!shf_ovf);
        if (shf_cnt[CNT_W-1] && shf_arith && shf_din[MSB])
            p_sign_fill_r3: assert (shf_dout[MSB]);
        if (shf_cnt[CNT_W-1] && !shf_arith)
            p_zero_fill_r3: assert (!shf_dout[MSB]);
        if (!shf_cnt[CNT_W-1] && shf_cnt != '0)
            p_low_zero_r1: assert (!shf_dout[0]);
        if (shf_cnt[CNT_W-1])
            p_right_no_ovf_r7: assert (!shf_ovf);
    end

endmodule

// File: tb/sr_barrel_shifter_tb.sv
`timescale 1ns/1ps
module sr_barrel_shifter_tb;

    localparam int DW = 40;
    localparam int CW = 6;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic [CW-1:0] cnt = '0;
    logic          arith = 1'b0;
    logic [DW-1:0] dout;
    logic          ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sr_barrel_shifter u_dut (
        .shf_din   (din),
        .shf_cnt   (cnt),
        .shf_arith (arith),
        .shf_dout  (dout),
        .shf_ovf   (ovf)
    );

    // {din, count, arith, expected dout, expected ovf}
    localparam logic [87:0] VEC [NV] = '{
        {40'h00_0000_0001, 6'h04, 1'b0, 40'h00_0000_0010, 1'b0},  // R1
        {40'h80_0000_0000, 6'h3C, 1'b1, 40'hF8_0000_0000, 1'b0},  // R3
        {40'h80_0000_0000, 6'h3C, 1'b0, 40'h08_0000_0000, 1'b0},  // R3
        {40'h00_0000_0001, 6'h1F, 1'b1, 40'h00_8000_0000, 1'b0},  // R1
        {40'h40_0000_0000, 6'h01, 1'b1, 40'h80_0000_0000, 1'b1},  // R6
        {40'h40_0000_0000, 6'h01, 1'b0, 40'h80_0000_0000, 1'b0},  // R7
        {40'hFF_FFFF_FFFF, 6'h30, 1'b1, 40'hFF_FFFF_FFFF, 1'b0},  // R3
        {40'hFF_FFFF_FFFF, 6'h30, 1'b0, 40'h00_00FF_FFFF, 1'b0},  // R2
        {40'h12_3456_7890, 6'h20, 1'b0, 40'h00_0012_3456, 1'b0},  // R4
        {40'hA5_A5A5_A5A5, 6'h00, 1'b1, 40'hA5_A5A5_A5A5, 1'b0},  // R5
        {40'hFF_FFFF_FFFF, 6'h08, 1'b1, 40'hFF_FFFF_FF00, 1'b0},  // R6
        {40'h12_3456_7890, 6'h08, 1'b1, 40'h34_5678_9000, 1'b1},  // R6
        {40'h12_3456_7890, 6'h38, 1'b1, 40'h00_1234_5678, 1'b0},  // R2
        {40'h80_0000_0001, 6'h3F, 1'b0, 40'h40_0000_0000, 1'b0},  // R3
        {40'h80_0000_0001, 6'h3F, 1'b1, 40'hC0_0000_0000, 1'b0},  // R3
        {40'h80_0000_0000, 6'h28, 1'b1, 40'hFF_FF80_0000, 1'b0}   // R4
    };
    string vec_req [NV] = '{"R1", "R3", "R3", "R1", "R6", "R7", "R3", "R2",
                            "R4", "R5", "R6", "R6", "R2", "R3", "R3", "R4"};

    task automatic check(input string req, input logic [DW-1:0] exp_d, input logic exp_o);
        n_chk++;
        if (dout !== exp_d || ovf !== exp_o) begin
            n_fail++;
            $display("FAIL %s: din=%h cnt=%h arith=%0b got dout=%h ovf=%0b expected dout=%h ovf=%0b",
                     req, din, cnt, arith, dout, ovf, exp_d, exp_o);
        end
    endtask

    task automatic apply(input logic [DW-1:0] d, input logic [CW-1:0] c, input logic a);
        @(negedge clk);
        din = d; cnt = c; arith = a;
        #1;
    endtask

    // Independent model built on wide shift operators
    task automatic model(input logic [DW-1:0] d, input logic [CW-1:0] c, input logic a,
                         output logic [DW-1:0] rd, output logic ro);
        int sc;
        logic [2*DW-1:0] wide;
        sc = $signed(c);
        if (sc < -16) sc = -16;
        ro = 1'b0;
        if (sc >= 0) begin
            wide = {{DW{d[DW-1]}}, d} << sc;
            rd   = wide[DW-1:0];
            ro   = a && !((wide[2*DW-1:DW-1] == '0) || (&wide[2*DW-1:DW-1]));
        end else begin
            wide = a ? {{DW{d[DW-1]}}, d} : {{DW{1'b0}}, d};
            wide = wide >> (-sc);
            rd   = wide[DW-1:0];
        end
    endtask

    initial begin
        logic [DW-1:0] ed;
        logic          eo;
        logic [DW-1:0] pats [4];
        pats[0] = 40'h80_0000_0000;
        pats[1] = 40'hFF_FFFF_FFFF;
        pats[2] = 40'h12_3456_7890;
        pats[3] = 40'h00_0000_0001;

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset state: zero inputs give zero output (R5)
        apply('0, '0, 1'b0);
        check("R5", '0, 1'b0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][87:48], VEC[v][47:42], VEC[v][41]);
            check(vec_req[v], VEC[v][40:1], VEC[v][0]);
        end

        // R8: output follows the inputs between clock edges
        @(negedge clk);
        din = 40'h00_0000_0003; cnt = 6'h02; arith = 1'b0;
        #0.5;
        check("R8", 40'h00_0000_000C, 1'b0);
        cnt = 6'h3F;
        #0.5;
        check("R8", 40'h00_0000_0001, 1'b0);

        // Full sweep of every count code in both modes (R1 R2 R3 R4 R6 R7)
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 64; c++) begin
                for (int a = 0; a < 2; a++) begin
                    apply(pats[p], CW'(c), a[0]);
                    model(pats[p], CW'(c), a[0], ed, eo);
                    if (c == 0)
                        check("R5", ed, eo);
                    else if (c < 32)
                        check(a[0] ? "R6" : "R1", ed, eo);
                    else if (c < 48)
                        check("R4", ed, eo);
                    else
                        check(a[0] ? "R3" : "R2", ed, eo);
                end
            end
        end

        // R7: right shifts never flag, even with a sign change pattern
        apply(40'h7F_FFFF_FFFF, 6'h30, 1'b1);
        check("R7", 40'h00_007F_FFFF, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule